// File: doc/BRIEF.md
# Looping Test-Vector Playback Sequencer

This block steps through a stored test program one line per clock and drives each line's vector onto the pins of a device under test. It presents a line address, and the vector store answers in the same cycle with the vector and the loop-control fields for that line. A line can open a loop. The loop runs from that line to a named end line and repeats a given number of times. Up to two loops may be active at once, one inside the other. A per-bit direction mask chooses, for each pin, whether the block drives it or samples it.

The vector for each line is applied in the cycle after its address is presented. The pins are sampled during that same cycle. The sampled value goes to a circular capture store together with the line number that produced it and the iteration index at each loop level. This keeps every output traceable to its stimulus when lines are replayed. Playback starts on a start pulse and ends after the last program line. A third nested loop stops playback with an error.

Top module: `vseq_player`

## Requirements
- R1: A pulse on start_i clears all playback state. Playback then begins at line 0 on line_addr_o and advances one line per clock until line last_line_i has been applied.
- R2: A line with line_open_i=1 opens a loop spanning from itself to line_end_i, where line_end_i is at or after the opening line. The span plays line_count_i times before playback continues after the end line. A count of 0 or 1 plays the span once.
- R3: Loops nest two deep. The inner loop completes all its repeats in every pass of the outer loop. When both loops end on the same line, the inner loop is finished first and the outer loop then repeats from its own start.
- R4: A loop whose start and end are the same line repeats that single line line_count_i times.
- R5: An attempt to open a loop while two are already active sets error_o and stops playback without applying or capturing that line. error_o stays high and no captures occur until the next start_i.
- R6: While a line is being applied, pin_oe_o equals dir_i and pin_out_o equals the line vector masked by dir_i (1 = drive). Both are zero when no line is being applied.
- R7: In each apply cycle cap_we_o is 1 and cap_data_o equals pin_in_i with all driven bits (dir_i=1) forced to 0.
- R8: cap_addr_o is 0 for the first capture after start_i and advances by one per capture. After CAP_DEPTH-1 it wraps to 0, and it holds between captures.
- R9: Each capture carries the applied line on cap_line_o. cap_iter0_o gives the 0-based pass index of the outermost open loop and cap_iter1_o gives that of the loop nested inside it. A level with no open loop reports 0.
- R10: done_o rises one cycle after the cycle in which the last line is applied and captured. It stays high with no further captures until the next start_i, and busy_o is low while done_o is high.
- R11: After reset, busy_o, done_o, error_o, cap_we_o and pin_oe_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one vector per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start playback from line 0 |
| last_line_i | input | LINE_AW | Final line of the program |
| dir_i | input | VEC_W | Per-pin direction, 1 = drive |
| line_addr_o | output | LINE_AW | Line being fetched |
| line_vec_i | input | VEC_W | Vector of the fetched line |
| line_open_i | input | 1 | Fetched line opens a loop |
| line_end_i | input | LINE_AW | End line of that loop |
| line_count_i | input | CNT_W | Repeat count of that loop |
| pin_out_o | output | VEC_W | Driven pin values |
| pin_oe_o | output | VEC_W | Pin output enables |
| pin_in_i | input | VEC_W | Sampled pin values |
| cap_we_o | output | 1 | Capture write strobe |
| cap_addr_o | output | $clog2(CAP_DEPTH) | Capture slot |
| cap_data_o | output | VEC_W | Captured sampled bits |
| cap_line_o | output | LINE_AW | Line that produced the capture |
| cap_iter0_o | output | CNT_W | Outer loop pass index |
| cap_iter1_o | output | CNT_W | Inner loop pass index |
| busy_o | output | 1 | Playback in progress |
| done_o | output | 1 | Program finished |
| error_o | output | 1 | Nesting limit exceeded |

## Verification
The bench targets two-level replay, including the case where both loops end on the same line. A design that pops only one level per line there either loops forever or skips the second outer pass. It also checks single-line loops and counts of 0 and 1, where an off-by-one in the repeat logic adds or drops replays. Iteration tags are checked across a pointer wrap: a design that re-opens a loop on its own jump target resets the tags and never terminates. The nesting-overflow program confirms that the offending line is neither applied nor captured, and that done_o follows the final capture by exactly one cycle.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int LOOP_NEST = 2;

  typedef enum logic [2:0] {
    VS_IDLE,
    VS_RUN,
    VS_DRAIN,
    VS_DONE,
    VS_FAULT
  } vs_state_e;
endpackage

// File: rtl/vseq_loop_stack.sv
module vseq_loop_stack #(
  parameter int AW   = 8,
  parameter int CW   = 8,
  parameter int NEST = vseq_pkg::LOOP_NEST
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     step_i,
  input  logic                     open_i,
  input  logic [AW-1:0]            pc_i,
  input  logic [AW-1:0]            end_i,
  input  logic [CW-1:0]            count_i,
  output logic                     jump_o,
  output logic [AW-1:0]            target_o,
  output logic                     overflow_o,
  output logic [NEST-1:0][CW-1:0]  iter_o
);
  localparam int DW = $clog2(NEST + 1);

  logic [NEST-1:0][AW-1:0] st_q, st_d, en_q, en_d;
  logic [NEST-1:0][CW-1:0] cn_q, cn_d, it_q, it_d;
  logic [DW-1:0]           dep_q, dep_d, dep_eff;
  logic                    scan;

  always_comb begin
    st_d = st_q; en_d = en_q; cn_d = cn_q; it_d = it_q;
    dep_eff    = dep_q;
    overflow_o = 1'b0;
    jump_o     = 1'b0;
    target_o   = '0;
    if (open_i) begin
      if (dep_q == DW'(NEST)) overflow_o = 1'b1;
      else begin
        for (int i = 0; i < NEST; i++) begin
          if (DW'(i) == dep_q) begin
            st_d[i] = pc_i;
            en_d[i] = end_i;
            cn_d[i] = count_i;
            it_d[i] = '0;
          end
        end
        dep_eff = DW'(dep_q + 1'b1);
      end
    end
    // tags reflect the pass the current line belongs to
    for (int i = 0; i < NEST; i++)
      iter_o[i] = (DW'(i) < dep_eff) ? it_d[i] : '0;
    // innermost first; a finished level pops and exposes the next one
    dep_d = dep_eff;
    scan  = 1'b1;
    for (int i = NEST - 1; i >= 0; i--) begin
      if (scan && DW'(i) < dep_eff) begin
        if (en_d[i] == pc_i) begin
          if (cn_d[i] > CW'(1)) begin
            jump_o   = 1'b1;
            target_o = st_d[i];
            cn_d[i]  = cn_d[i] - 1'b1;
            it_d[i]  = it_d[i] + 1'b1;
            scan     = 1'b0;
          end else begin
            dep_d = DW'(i);
          end
        end else begin
          scan = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0; en_q <= '0; cn_q <= '0; it_q <= '0; dep_q <= '0;
    end else if (clear_i) begin
      dep_q <= '0;
    end else if (step_i && !overflow_o) begin
      st_q <= st_d; en_q <= en_d; cn_q <= cn_d; it_q <= it_d; dep_q <= dep_d;
    end
  end

  a_r5_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dep_q <= DW'(NEST));
endmodule

// File: rtl/vseq_capture.sv
module vseq_capture #(
  parameter int W     = 96,
  parameter int AW    = 8,
  parameter int CW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     apply_i,
  input  logic [W-1:0]             vec_i,
  input  logic [AW-1:0]            line_i,
  input  logic [CW-1:0]            iter0_i,
  input  logic [CW-1:0]            iter1_i,
  input  logic [W-1:0]             dir_i,
  input  logic [W-1:0]             pin_in_i,
  output logic [W-1:0]             pin_out_o,
  output logic [W-1:0]             pin_oe_o,
  output logic                     cap_we_o,
  output logic [$clog2(DEPTH)-1:0] cap_addr_o,
  output logic [W-1:0]             cap_data_o,
  output logic [AW-1:0]            cap_line_o,
  output logic [CW-1:0]            cap_iter0_o,
  output logic [CW-1:0]            cap_iter1_o
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic          v_q;
  logic [W-1:0]  vec_q;
  logic [PW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= 1'b0; vec_q <= '0; ptr_q <= '0;
      cap_line_o <= '0; cap_iter0_o <= '0; cap_iter1_o <= '0;
    end else begin
      v_q <= apply_i && !clear_i;
      if (apply_i) begin
        vec_q       <= vec_i;
        cap_line_o  <= line_i;
        cap_iter0_o <= iter0_i;
        cap_iter1_o <= iter1_i;
      end
      if (clear_i)  ptr_q <= '0;
      else if (v_q) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  assign pin_oe_o   = v_q ? dir_i : '0;
  assign pin_out_o  = v_q ? (vec_q & dir_i) : '0;
  assign cap_we_o   = v_q;
  assign cap_addr_o = ptr_q;
  assign cap_data_o = pin_in_i & ~dir_i;

  a_r8_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_we_o && cap_addr_o == LAST |=> cap_addr_o == '0);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_we_o && !clear_i |=> $stable(cap_addr_o));
endmodule

// File: rtl/vseq_player.sv
module vseq_player #(
  parameter int VEC_W     = 96,
  parameter int LINE_AW   = 8,
  parameter int CNT_W     = 8,
  parameter int CAP_DEPTH = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [LINE_AW-1:0]           last_line_i,
  input  logic [VEC_W-1:0]             dir_i,
  output logic [LINE_AW-1:0]           line_addr_o,
  input  logic [VEC_W-1:0]             line_vec_i,
  input  logic                         line_open_i,
  input  logic [LINE_AW-1:0]           line_end_i,
  input  logic [CNT_W-1:0]             line_count_i,
  output logic [VEC_W-1:0]             pin_out_o,
  output logic [VEC_W-1:0]             pin_oe_o,
  input  logic [VEC_W-1:0]             pin_in_i,
  output logic                         cap_we_o,
  output logic [$clog2(CAP_DEPTH)-1:0] cap_addr_o,
  output logic [VEC_W-1:0]             cap_data_o,
  output logic [LINE_AW-1:0]           cap_line_o,
  output logic [CNT_W-1:0]             cap_iter0_o,
  output logic [CNT_W-1:0]             cap_iter1_o,
  output logic                         busy_o,
  output logic                         done_o,
  output logic                         error_o
);
  import vseq_pkg::*;
  localparam int NEST = LOOP_NEST;

  vs_state_e                    state_q;
  logic [LINE_AW-1:0]           pc_q;
  logic                         skip_q;
  logic                         step, apply, jump, ovf;
  logic [LINE_AW-1:0]           target;
  logic [NEST-1:0][CNT_W-1:0]   iter;

  assign step  = (state_q == VS_RUN) && !start_i;
  assign apply = step && !ovf;

  vseq_loop_stack #(.AW(LINE_AW), .CW(CNT_W), .NEST(NEST)) u_stack (
    .clk_i, .rst_ni,
    .clear_i   (start_i),
    .step_i    (step),
    .open_i    (line_open_i && !skip_q),
    .pc_i      (pc_q),
    .end_i     (line_end_i),
    .count_i   (line_count_i),
    .jump_o    (jump),
    .target_o  (target),
    .overflow_o(ovf),
    .iter_o    (iter)
  );

  vseq_capture #(.W(VEC_W), .AW(LINE_AW), .CW(CNT_W), .DEPTH(CAP_DEPTH)) u_cap (
    .clk_i, .rst_ni,
    .clear_i    (start_i),
    .apply_i    (apply),
    .vec_i      (line_vec_i),
    .line_i     (pc_q),
    .iter0_i    (iter[0]),
    .iter1_i    (iter[1]),
    .dir_i,
    .pin_in_i,
    .pin_out_o,
    .pin_oe_o,
    .cap_we_o,
    .cap_addr_o,
    .cap_data_o,
    .cap_line_o,
    .cap_iter0_o,
    .cap_iter1_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= VS_IDLE; pc_q <= '0; skip_q <= 1'b0;
    end else if (start_i) begin
      state_q <= VS_RUN; pc_q <= '0; skip_q <= 1'b0;
    end else if (step) begin
      if (ovf) state_q <= VS_FAULT;
      else if (jump) begin
        pc_q   <= target;
        skip_q <= 1'b1;  // landing on an opening line must not push it again
      end else if (pc_q == last_line_i) state_q <= VS_DRAIN;
      else begin
        pc_q   <= pc_q + 1'b1;
        skip_q <= 1'b0;
      end
    end else if (state_q == VS_DRAIN) state_q <= VS_DONE;
  end

  assign line_addr_o = pc_q;
  assign busy_o      = (state_q == VS_RUN) || (state_q == VS_DRAIN);
  assign done_o      = (state_q == VS_DONE);
  assign error_o     = (state_q == VS_FAULT);

  a_r10_done_after_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(cap_we_o));
  a_r5_no_cap_on_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !cap_we_o);
  a_r2_replay_backward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && jump && !ovf |=> line_addr_o <= $past(line_addr_o));
endmodule

// File: tb/vseq_player_test.sv
`timescale 1ns/1ps
module vseq_player_test;
  localparam int W = 96;
  localparam int H = W / 2;

  // expected capture stream of the main program: line + 256*iter0 + 65536*iter1
  localparam int MAIN_N = 20;
  localparam int MAIN_EXP [MAIN_N] = '{
    0, 1, 2, 3, 65538, 65539, 131074, 131075, 4, 5,
    257, 258, 259, 65794, 65795, 131330, 131331, 260, 261, 6};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [7:0]    last_line = '0;
  logic [W-1:0]  dir = {{H{1'b0}}, {H{1'b1}}};
  logic [7:0]    line_addr;
  logic [W-1:0]  line_vec;
  logic          line_open;
  logic [7:0]    line_end, line_count;
  logic [W-1:0]  pin_out, pin_oe, pin_in;
  logic          cap_we;
  logic [3:0]    cap_addr;
  logic [W-1:0]  cap_data;
  logic [7:0]    cap_line, cap_i0, cap_i1;
  logic          busy, done, err;

  bit            p_open [16];
  logic [7:0]    p_end  [16];
  logic [7:0]    p_cnt  [16];
  int            exp_q  [32];
  int            n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  function automatic logic [W-1:0] vec_of(input int l);
    logic [7:0] b;
    b = 8'(l * 29 + 7);
    return {12{b}};
  endfunction

  always_comb begin
    line_vec   = vec_of(int'(line_addr[3:0]));
    line_open  = p_open[line_addr[3:0]];
    line_end   = p_end[line_addr[3:0]];
    line_count = p_cnt[line_addr[3:0]];
  end
  // device model: driven low half loops back onto the sampled high half
  assign pin_in = {pin_out[H-1:0], pin_out[H-1:0]};

  vseq_player uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .last_line_i(last_line), .dir_i(dir),
    .line_addr_o(line_addr), .line_vec_i(line_vec), .line_open_i(line_open),
    .line_end_i(line_end), .line_count_i(line_count),
    .pin_out_o(pin_out), .pin_oe_o(pin_oe), .pin_in_i(pin_in),
    .cap_we_o(cap_we), .cap_addr_o(cap_addr), .cap_data_o(cap_data),
    .cap_line_o(cap_line), .cap_iter0_o(cap_i0), .cap_iter1_o(cap_i1),
    .busy_o(busy), .done_o(done), .error_o(err));

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) begin
      p_open[i] = 1'b0; p_end[i] = '0; p_cnt[i] = '0;
    end
  endtask

  task automatic set_loop(input int l, input int e, input int c);
    p_open[l] = 1'b1; p_end[l] = 8'(e); p_cnt[l] = 8'(c);
  endtask

  task automatic run_prog(input int last, input int nexp, input bit want_err);
    int n = 0, lastcap = -10, endcyc = -1, e;
    logic [W-1:0] xd;
    @(negedge clk);
    last_line = 8'(last);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      if (cap_we) begin
        if (n < nexp) begin
          e  = exp_q[n];
          xd = {vec_of(e & 255)[H-1:0], {H{1'b0}}};
          chk(cap_line == 8'(e & 255) && cap_i0 == 8'((e >> 8) & 255) && cap_i1 == 8'(e >> 16),
              "R9 tag {line,i0,i1}", {cap_i1, cap_i0, cap_line}, 24'(e));
          chk(cap_addr == 4'(n % 16), "R8 capture slot", cap_addr, n % 16);
          chk(cap_data == xd, "R7 captured data", cap_data, xd);
          chk(pin_oe == dir && pin_out == (vec_of(e & 255) & dir), "R6 pin drive", pin_out, vec_of(e & 255) & dir);
        end else chk(1'b0, "R1 extra capture", n, nexp);
        chk(!done, "R10 done early", done, 0);
        n++;
        lastcap = cyc;
      end
      if (done || err) begin
        endcyc = cyc;
        break;
      end
    end
    chk(n == nexp, "R1 capture count", n, nexp);
    if (want_err) begin
      chk(err && !done && !busy, "R5 fault state", {err, done, busy}, 3'b100);
    end else begin
      chk(done && !err && !busy, "R10 done state", {err, done, busy}, 3'b010);
      chk(endcyc == lastcap + 1, "R10 done timing", endcyc - lastcap, 1);
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!cap_we && (want_err ? err : done), "R10 R5 sticky end", {cap_we, err, done}, {1'b0, want_err, !want_err});
    end
  endtask

  initial begin
    #(8ns * 200000);
    n_bad++;
    $display("FAIL watchdog expired act=%0d exp=0", n_chk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_prog();
    #20 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && !cap_we && pin_oe == '0, "R11 reset state",
        {busy, done, err, cap_we, |pin_oe}, 0);

    // R2 R3: outer 1..5 x2 with inner 2..3 x3; wraps capture slots (R8)
    clear_prog();
    set_loop(1, 5, 2);
    set_loop(2, 3, 3);
    for (int i = 0; i < MAIN_N; i++) exp_q[i] = MAIN_EXP[i];
    run_prog(6, MAIN_N, 1'b0);

    // R4: single-line loop repeated three times
    clear_prog();
    set_loop(1, 1, 3);
    exp_q[0] = 0; exp_q[1] = 1; exp_q[2] = 257; exp_q[3] = 513; exp_q[4] = 2;
    run_prog(2, 5, 1'b0);

    // R2: counts 0 and 1 both play once
    clear_prog();
    set_loop(0, 1, 0);
    set_loop(2, 3, 1);
    for (int i = 0; i < 4; i++) exp_q[i] = i;
    run_prog(3, 4, 1'b0);

    // R3: both loops end on line 2
    clear_prog();
    set_loop(0, 2, 2);
    set_loop(1, 2, 2);
    exp_q[0] = 0;   exp_q[1] = 1;   exp_q[2] = 2;   exp_q[3] = 65537; exp_q[4] = 65538;
    exp_q[5] = 256; exp_q[6] = 257; exp_q[7] = 258; exp_q[8] = 65793; exp_q[9] = 65794;
    run_prog(2, 10, 1'b0);

    // R5: third nested open at line 2 stops before applying it
    clear_prog();
    set_loop(0, 5, 2);
    set_loop(1, 4, 2);
    set_loop(2, 3, 2);
    exp_q[0] = 0; exp_q[1] = 1;
    run_prog(6, 2, 1'b1);

    // R1: restart after fault begins again at line 0, slot 0
    clear_prog();
    for (int i = 0; i < 3; i++) exp_q[i] = i;
    run_prog(2, 3, 1'b0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule